// File: doc/BRIEF.md
# Scratch-Pad Register File with Remapped Slots

This block is the working-register store of a small 8-bit accumulator processor. Seven 8-bit registers are named by a 3-bit code: A is 000, B 001, C 010, D 011, E 100, H 101 and L 110. The eighth code, 111, holds no data. It stands for the memory operand, whose address is built from H and L. The block holds the registers, applies the per-cycle operation chosen by the decoder, and presents the selected value and the memory operand address to the rest of the core.

Storage is not laid out by code. Each code is placed in a physical slot `{c2^c1, c1^c0, c0}`, which puts A in slot 0 and leaves slot 1 (the code 111 position) as a hole with no flops. The accumulator slot can rotate through a carry input. The other six slots can count up or down. Any slot can be loaded from the write bus, and this is how ALU results reach the accumulator.

Top module: `scratchpad_regfile`

## Requirements
- R1: After reset, every register reads 0x00, `carry_out` is 0 and `count_zero` is 0.
- R2: `rdata` shows the current value of the register named by `sel` for codes 000 to 110, combinationally. Code 111 reads 0x00.
- R3: When `wr_en` is high and `sel` is 000 to 110, the named register holds `wdata` after the next rising clock edge.
- R4: When `sel` is 111 and the winning operation is a write, increment or decrement, no register changes. `mem_req` is high in that same cycle, and it is low in every other case.
- R5: When increment wins and `sel` is 001 to 110, the register gains 1 modulo 256. `count_zero` then shows whether the result is 0x00.
- R6: When decrement wins and `sel` is 001 to 110, the register loses 1 modulo 256. `count_zero` then shows whether the result is 0x00.
- R7: Increment or decrement with `sel` = 000 leaves A unchanged and leaves `count_zero` unchanged. `count_zero` also holds in every cycle without an applied count.
- R8: When rotate-left wins, A becomes `{A[6:0], carry_in}` and `carry_out` takes the old A[7], whatever `sel` is.
- R9: When rotate-right wins, A becomes `{carry_in, A[7:1]}` and `carry_out` takes the old A[0], whatever `sel` is. `carry_out` holds when no rotate is applied.
- R10: Only one operation takes effect per cycle. The priority is write, then increment, then decrement, then rotate-left, then rotate-right.
- R11: `mem_addr` is always `{H[5:0], L}`, and the top two bits of H are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 3 | Register code (111 = memory operand) |
| wdata | input | 8 | Write data bus |
| wr_en | input | 1 | Load selected register |
| inc | input | 1 | Increment selected register |
| dec | input | 1 | Decrement selected register |
| rot_left | input | 1 | Rotate accumulator left through carry_in |
| rot_right | input | 1 | Rotate accumulator right through carry_in |
| carry_in | input | 1 | Bit shifted into the accumulator |
| rdata | output | 8 | Value of selected register |
| mem_addr | output | 14 | Memory operand address from H and L |
| mem_req | output | 1 | Operation targets the memory operand |
| carry_out | output | 1 | Bit last shifted out of the accumulator |
| count_zero | output | 1 | Last applied count produced 0x00 |

## Verification
The first directed pattern writes a distinct value to every code and reads each one back. A wrong XOR placement then shows as an aliased or lost register. Counting runs through 0xFF to 0x00 and 0x00 to 0xFF, which separates correct modulo wrap from a stuck or saturating counter. Counts aimed at code 000 and 111 separate "ignored" from "applied to the wrong slot". Rotates are issued with `sel` pointing elsewhere and with both carry values, and colliding control pairs check the priority order. A long run of random controls is then compared every cycle against a behavioural model indexed by code, not by slot.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int CODE_W = 3;
  localparam int SLOTS  = 1 << CODE_W;

  typedef enum logic [2:0] {
    OP_NONE, OP_WR, OP_INC, OP_DEC, OP_ROL, OP_ROR
  } sp_op_e;

  localparam logic [CODE_W-1:0] CODE_ACC = 3'b000;
  localparam logic [CODE_W-1:0] CODE_H   = 3'b101;
  localparam logic [CODE_W-1:0] CODE_L   = 3'b110;
  localparam logic [CODE_W-1:0] CODE_MEM = 3'b111;

  // Physical placement of a register code.
  function automatic logic [CODE_W-1:0] slot_of(input logic [CODE_W-1:0] c);
    return {c[2] ^ c[1], c[1] ^ c[0], c[0]};
  endfunction
endpackage

// File: rtl/sp_op_select.sv
module sp_op_select
  import sp_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              wr_en,
  input  logic              inc,
  input  logic              dec,
  input  logic              rot_left,
  input  logic              rot_right,
  output sp_op_e            op,
  output logic [CODE_W-1:0] slot,
  output logic              is_mem,
  output logic              apply,
  output logic              mem_req
);
  always_comb begin
    if (wr_en)          op = OP_WR;
    else if (inc)       op = OP_INC;
    else if (dec)       op = OP_DEC;
    else if (rot_left)  op = OP_ROL;
    else if (rot_right) op = OP_ROR;
    else                op = OP_NONE;
  end

  assign slot   = slot_of(code);
  assign is_mem = (code == CODE_MEM);

  logic reg_op, count_op;
  assign count_op = (op == OP_INC) || (op == OP_DEC);
  assign reg_op   = (op == OP_WR) || count_op;

  // A register op lands in storage unless it names the memory operand,
  // and counts never touch the accumulator.
  assign apply   = reg_op && !is_mem && !(count_op && code == CODE_ACC);
  assign mem_req = reg_op && is_mem;
endmodule

// File: rtl/sp_slot_bank.sv
module sp_slot_bank
  import sp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  sp_op_e                        op,
  input  logic [CODE_W-1:0]             slot,
  input  logic                          apply,
  input  logic [DATA_W-1:0]             wdata,
  input  logic                          carry_in,
  output logic [SLOTS-1:0][DATA_W-1:0]  slot_q,
  output logic                          carry_out,
  output logic                          count_zero
);
  localparam logic [CODE_W-1:0] SLOT_ACC  = slot_of(CODE_ACC);
  localparam logic [CODE_W-1:0] SLOT_HOLE = slot_of(CODE_MEM);

  function automatic logic [DATA_W-1:0] count_step(input logic [DATA_W-1:0] v,
                                                   input logic up);
    return up ? v + 1'b1 : v - 1'b1;
  endfunction

  // Returns {bit shifted out, new value}.
  function automatic logic [DATA_W:0] rotate_c(input logic [DATA_W-1:0] v,
                                               input logic ci, input logic left);
    return left ? {v[DATA_W-1], v[DATA_W-2:0], ci}
                : {v[0], ci, v[DATA_W-1:1]};
  endfunction

  logic [DATA_W-1:0] cur_val, step_val, rot_val;
  logic              rot_co, rot_ev, count_ev;

  assign cur_val           = slot_q[slot];
  assign step_val          = count_step(cur_val, op == OP_INC);
  assign {rot_co, rot_val} = rotate_c(slot_q[SLOT_ACC], carry_in, op == OP_ROL);
  assign rot_ev            = (op == OP_ROL) || (op == OP_ROR);
  assign count_ev          = apply && ((op == OP_INC) || (op == OP_DEC));

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (CODE_W'(s) == SLOT_HOLE) begin : g_hole
      assign slot_q[s] = '0;
    end else begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= '0;
        else if (apply && slot == CODE_W'(s))
          q <= (op == OP_WR) ? wdata : step_val;
        else if (CODE_W'(s) == SLOT_ACC && rot_ev)
          q <= rot_val;
      end
      assign slot_q[s] = q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_out  <= 1'b0;
      count_zero <= 1'b0;
    end else begin
      if (rot_ev)   carry_out  <= rot_co;
      if (count_ev) count_zero <= (step_val == '0);
    end
  end
endmodule

// File: rtl/scratchpad_regfile.sv
module scratchpad_regfile
  import sp_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int HI_BITS = 6,
  localparam int ADDR_W = HI_BITS + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              inc,
  input  logic              dec,
  input  logic              rot_left,
  input  logic              rot_right,
  input  logic              carry_in,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_req,
  output logic              carry_out,
  output logic              count_zero
);
  localparam logic [CODE_W-1:0] SLOT_ACC = slot_of(CODE_ACC);
  localparam logic [CODE_W-1:0] SLOT_H   = slot_of(CODE_H);
  localparam logic [CODE_W-1:0] SLOT_L   = slot_of(CODE_L);

  sp_op_e                       op;
  logic [CODE_W-1:0]            slot;
  logic                         is_mem, apply;
  logic [SLOTS-1:0][DATA_W-1:0] slot_q;
  logic [DATA_W-1:0]            acc_q;

  sp_op_select u_sel (
    .code(sel), .wr_en(wr_en), .inc(inc), .dec(dec),
    .rot_left(rot_left), .rot_right(rot_right),
    .op(op), .slot(slot), .is_mem(is_mem), .apply(apply), .mem_req(mem_req)
  );

  sp_slot_bank #(.DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .op(op), .slot(slot), .apply(apply),
    .wdata(wdata), .carry_in(carry_in), .slot_q(slot_q),
    .carry_out(carry_out), .count_zero(count_zero)
  );

  assign acc_q    = slot_q[SLOT_ACC];
  assign rdata    = is_mem ? '0 : slot_q[slot];
  assign mem_addr = {slot_q[SLOT_H][HI_BITS-1:0], slot_q[SLOT_L]};

  logic count_hit;
  assign count_hit = apply && (op == OP_INC || op == OP_DEC);

  // R4: a memory-operand access leaves every slot untouched
  a_r4_mem_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> $stable(slot_q));

  // R3: a write lands in the slot chosen by the code
  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && op == OP_WR) |=> slot_q[$past(slot)] == $past(wdata));

  // R5
  a_r5_inc_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && op == OP_INC) |=> slot_q[$past(slot)] == DATA_W'($past(rdata) + 1'b1));

  // R6
  a_r6_dec_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && op == OP_DEC) |=> slot_q[$past(slot)] == DATA_W'($past(rdata) - 1'b1));

  // R5 / R6: zero indication follows the counted result
  a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    count_hit |=> count_zero == (slot_q[$past(slot)] == '0));

  // R7: counts aimed at the accumulator change nothing
  a_r7_acc_count_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_INC || op == OP_DEC) && sel == CODE_ACC) |=> ($stable(acc_q) && $stable(count_zero)));

  // R8
  a_r8_rotate_left: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ROL) |=> (acc_q == {$past(acc_q[DATA_W-2:0]), $past(carry_in)}
                        && carry_out == $past(acc_q[DATA_W-1])));

  // R9
  a_r9_rotate_right: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ROR) |=> (acc_q == {$past(carry_in), $past(acc_q[DATA_W-1:1])}
                        && carry_out == $past(acc_q[0])));

  // R11: a rotate never disturbs the address pair
  a_r11_rotate_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ROL || op == OP_ROR) |=> $stable(mem_addr));
endmodule

// File: tb/tb_scratchpad_regfile.sv
`timescale 1ns/1ps
module tb_scratchpad_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 0, inc = 0, dec = 0, rot_left = 0, rot_right = 0, carry_in = 0;
  logic [7:0]  rdata;
  logic [13:0] mem_addr;
  logic        mem_req, carry_out, count_zero;

  scratchpad_regfile dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wdata(wdata), .wr_en(wr_en),
    .inc(inc), .dec(dec), .rot_left(rot_left), .rot_right(rot_right),
    .carry_in(carry_in), .rdata(rdata), .mem_addr(mem_addr),
    .mem_req(mem_req), .carry_out(carry_out), .count_zero(count_zero)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference state indexed by register code (0..6).
  int m_reg[7];
  int m_cy = 0;
  int m_z  = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int s, input int d, input bit w, input bit i,
                      input bit dn, input bit rl, input bit rr, input bit ci);
    int exp_rd, a;
    @(negedge clk);
    sel = 3'(s); wdata = 8'(d); wr_en = w; inc = i; dec = dn;
    rot_left = rl; rot_right = rr; carry_in = ci;
    #1;
    exp_rd = (s == 7) ? 0 : m_reg[s];
    chk("R2", int'(rdata), exp_rd);
    chk("R11", int'(mem_addr), ((m_reg[5] % 64) * 256) + m_reg[6]);
    chk("R4", int'(mem_req), int'((s == 7) && (w || i || dn)));
    chk("R9", int'(carry_out), m_cy);
    chk("R7", int'(count_zero), m_z);
    // model update, R10 priority
    if (w) begin
      if (s != 7) m_reg[s] = d % 256;
    end else if (i || dn) begin
      if (s != 7 && s != 0) begin
        m_reg[s] = (m_reg[s] + (i ? 1 : 255)) % 256;
        m_z = (m_reg[s] == 0);
      end
    end else if (rl) begin
      a = m_reg[0];
      m_cy = a / 128;
      m_reg[0] = ((a * 2) % 256) + ci;
    end else if (rr) begin
      a = m_reg[0];
      m_cy = a % 2;
      m_reg[0] = (a / 2) + (ci ? 128 : 0);
    end
  endtask

  task automatic rd(input int s);
    step(s, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 7; k++) m_reg[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state on every code
    for (int k = 0; k < 8; k++) rd(k);
    // R3: distinct values into each code, read all back (catches aliasing)
    for (int k = 0; k < 7; k++) step(k, 8'h13 * (k + 1), 1, 0, 0, 0, 0, 0);
    for (int k = 0; k < 8; k++) rd(k);
    // R11: top bits of H ignored
    step(5, 8'hFF, 1, 0, 0, 0, 0, 0);
    step(6, 8'h34, 1, 0, 0, 0, 0, 0);
    rd(0);
    // R4: write/inc/dec on code 111 change nothing
    step(7, 8'hAA, 1, 0, 0, 0, 0, 0);
    step(7, 0, 0, 1, 0, 0, 0, 0);
    step(7, 0, 0, 0, 1, 0, 0, 0);
    for (int k = 0; k < 8; k++) rd(k);
    // R5: wrap FF -> 00 sets zero, then 00 -> 01 clears it
    step(1, 8'hFF, 1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 1, 0, 0, 0, 0);
    step(1, 0, 0, 1, 0, 0, 0, 0);
    rd(1);
    // R6: wrap 00 -> FF
    step(2, 8'h01, 1, 0, 0, 0, 0, 0);
    step(2, 0, 0, 0, 1, 0, 0, 0);
    step(2, 0, 0, 0, 1, 0, 0, 0);
    rd(2);
    // R7: counts on A ignored
    step(0, 8'h80, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    rd(0);
    // R8: rotate-left with sel elsewhere, both carry values
    step(3, 0, 0, 0, 0, 1, 0, 1);
    step(4, 0, 0, 0, 0, 1, 0, 0);
    rd(0);
    // R9: rotate-right
    step(6, 0, 0, 0, 0, 0, 1, 1);
    step(6, 0, 0, 0, 0, 0, 1, 0);
    rd(0);
    // R10: colliding controls
    step(3, 8'h5A, 1, 1, 1, 1, 1, 1);
    step(3, 0, 0, 1, 1, 1, 1, 0);
    step(0, 0, 0, 0, 0, 1, 1, 1);
    step(7, 8'h11, 1, 0, 0, 1, 0, 1);
    for (int k = 0; k < 8; k++) rd(k);
    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 16);
      step(int'($urandom % 8), int'($urandom % 256),
           r == 0, r inside {1, 2, 3}, r inside {4, 5, 6},
           r inside {7, 8}, r inside {9, 10}, bit'($urandom % 2));
    end
    finish_run();
  end
endmodule